// File: doc/BRIEF.md
# Power Mode and Standby Controller

This block keeps track of the power mode of a system and decides when it moves between shut-down, start-up, normal operation and low-power standby. Two asynchronous standby request pins feed it, one from the main processor and one from the peripherals. Each pin has its own polarity bit. The block enters standby only when both pins ask for it at the same time. The requests count only in normal operation. During start-up and the watchdog wait they are ignored, so software can set the polarities once it runs.

A watchdog-alive input must stay high for the system to remain in normal operation or standby. When it drops, a configuration bit chooses whether the block shuts down or goes through a cold restart. Every input is sampled by the slow 32 kHz-domain clock. Start-up is modelled as a fixed, parameterized number of cycles. All ports are plain control and status signals: no data flows through the block, so no stream handshake is needed.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, `mode` is 0 (OFF) and `standby_active` is 0.
- R2: The mode encoding is OFF=0, STARTUP=1, ON=2, STANDBY=3, WATCHDOG=4, COLD_START=5. From OFF, a high `pwr_on_req` moves the block to STARTUP on the third clock edge after the input changes. STARTUP lasts `STARTUP_CYCLES` cycles (default 8) and then moves to WATCHDOG.
- R3: WATCHDOG holds until the synchronized `wdog_ok` is high, then moves to ON on the third edge after `wdog_ok` rises. In STARTUP and WATCHDOG, both standby pins and a low `wdog_ok` have no effect.
- R4: In ON, a standby event enters STANDBY. A standby event exists only when both the processor request and the peripheral request are asserted. One request alone keeps the block in ON.
- R5: A polarity bit of 1 makes its pin active high, and 0 makes it active low. The polarity is applied to the filtered pin level, so a change of polarity acts on the next clock edge.
- R6: Each standby pin passes through a two-flop synchronizer and then a filter that accepts a new level only after it has been stable for 3 sampled cycles. A level that lasts 2 cycles is ignored. A valid change reaches `mode` on the sixth edge after the pin changes.
- R7: In STANDBY, the mode returns to ON on the edge after the qualified standby event deasserts.
- R8: In ON or STANDBY, a low synchronized `wdog_ok` moves the block to OFF when `wdog_cold` is 0, or to COLD_START when it is 1. This takes priority over any standby decision.
- R9: COLD_START lasts exactly one cycle and then enters STARTUP.
- R10: `standby_active` is high only while `mode` is STANDBY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32 kHz-domain sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_on_req | input | 1 | Power-on request, asynchronous |
| sby_cpu_pin | input | 1 | Processor standby request pin, asynchronous |
| sby_per_pin | input | 1 | Peripheral standby request pin, asynchronous |
| cpu_pol_high | input | 1 | 1: processor pin is active high; 0: active low |
| per_pol_high | input | 1 | 1: peripheral pin is active high; 0: active low |
| wdog_ok | input | 1 | Watchdog-alive level, asynchronous |
| wdog_cold | input | 1 | Response to watchdog loss: 0 goes to OFF, 1 goes to COLD_START |
| mode | output | 3 | Current power mode |
| standby_active | output | 1 | High while in STANDBY |

## Verification
The bench targets the following corner cases:
- **Two-cycle glitch on a standby pin.** A filter that is one cycle too short would let the glitch into STANDBY.
- **Standby requested by one side only.** An OR decode instead of an AND would enter STANDBY.
- **Polarity flip while the pin is held.** If polarity were applied before the filter, the response would be delayed by six cycles or lost.
- **Standby event present from the start.** The event is kept asserted through start-up and the watchdog wait. A design that honoured the pins outside ON would leave STARTUP or WATCHDOG early. It must instead enter STANDBY one edge after reaching ON.
- **Watchdog loss under each configuration.** The bench drops `wdog_ok` with `wdog_cold` at 0 and at 1, while standby is held. A wrong priority would stay in STANDBY. A swapped configuration bit would land in the wrong mode, or skip the single cycle of COLD_START.

// File: rtl/pwrmode_pkg.sv
package pwrmode_pkg;
  typedef enum logic [2:0] {
    MODE_OFF      = 3'd0,
    MODE_STARTUP  = 3'd1,
    MODE_ON       = 3'd2,
    MODE_STANDBY  = 3'd3,
    MODE_WATCHDOG = 3'd4,
    MODE_COLD     = 3'd5
  } mode_t;
endpackage

// File: rtl/sync2.sv
module sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic stage1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= 1'b0;
      q      <= 1'b0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/sby_pin_qual.sv
// Synchronize one asynchronous pin, then accept a new level only after it
// has persisted for FILT_LEN consecutive sampled cycles.
module sby_pin_qual #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level
);
  localparam int FW = $clog2(FILT_LEN + 1);

  logic          pin_s;
  logic [FW-1:0] run_cnt;

  sync2 u_sync (.clk(clk), .rst_n(rst_n), .d(pin), .q(pin_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level   <= 1'b0;
      run_cnt <= '0;
    end else if (pin_s == level) begin
      run_cnt <= '0;
    end else if (run_cnt == FW'(FILT_LEN - 1)) begin
      level   <= pin_s;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
  import pwrmode_pkg::*;
#(
  parameter int STARTUP_CYCLES = 8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pwr_s,
  input  logic  wd_s,
  input  logic  sby_evt,
  input  logic  cold_cfg,
  output mode_t state,
  output logic  standby_active
);
  localparam int CW = $clog2(STARTUP_CYCLES + 1);

  mode_t         nxt;
  logic [CW-1:0] su_cnt;
  logic          su_done;

  assign su_done = (su_cnt == CW'(STARTUP_CYCLES - 1));

  always_comb begin
    nxt = state;
    unique case (state)
      MODE_OFF:      if (pwr_s) nxt = MODE_STARTUP;
      MODE_STARTUP:  if (su_done) nxt = MODE_WATCHDOG;
      MODE_WATCHDOG: if (wd_s) nxt = MODE_ON;
      MODE_ON: begin
        if (!wd_s)        nxt = cold_cfg ? MODE_COLD : MODE_OFF;
        else if (sby_evt) nxt = MODE_STANDBY;
      end
      MODE_STANDBY: begin
        if (!wd_s)         nxt = cold_cfg ? MODE_COLD : MODE_OFF;
        else if (!sby_evt) nxt = MODE_ON;
      end
      MODE_COLD:     nxt = MODE_STARTUP;
      default:       nxt = MODE_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= MODE_OFF;
      su_cnt <= '0;
    end else begin
      state <= nxt;
      if (state == MODE_STARTUP && !su_done) su_cnt <= su_cnt + 1'b1;
      else                                   su_cnt <= '0;
    end
  end

  assign standby_active = (state == MODE_STANDBY);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwrmode_pkg::*;
#(
  parameter int STARTUP_CYCLES = 8,
  parameter int FILT_LEN       = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_on_req,
  input  logic       sby_cpu_pin,
  input  logic       sby_per_pin,
  input  logic       cpu_pol_high,
  input  logic       per_pol_high,
  input  logic       wdog_ok,
  input  logic       wdog_cold,
  output logic [2:0] mode,
  output logic       standby_active
);
  localparam int NREQ = 2;

  logic [NREQ-1:0] pins, pol_high, lvl, req;
  logic            pwr_s, wd_s, sby_evt;
  mode_t           st;

  assign pins     = {sby_per_pin, sby_cpu_pin};
  assign pol_high = {per_pol_high, cpu_pol_high};

  for (genvar i = 0; i < NREQ; i++) begin : g_req
    sby_pin_qual #(.FILT_LEN(FILT_LEN)) u_qual (
      .clk(clk), .rst_n(rst_n), .pin(pins[i]), .level(lvl[i])
    );
    assign req[i] = pol_high[i] ? lvl[i] : ~lvl[i];
  end

  assign sby_evt = &req;

  sync2 u_pwr_sync (.clk(clk), .rst_n(rst_n), .d(pwr_on_req), .q(pwr_s));
  sync2 u_wd_sync  (.clk(clk), .rst_n(rst_n), .d(wdog_ok),    .q(wd_s));

  mode_fsm #(.STARTUP_CYCLES(STARTUP_CYCLES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .pwr_s(pwr_s), .wd_s(wd_s),
    .sby_evt(sby_evt), .cold_cfg(wdog_cold),
    .state(st), .standby_active(standby_active)
  );

  assign mode = st;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk
  import pwrmode_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode,
  input logic       standby_active,
  input logic       pwr_s,
  input logic       wd_s,
  input logic       sby_evt,
  input logic       wdog_cold
);
  // R2: only legal encodings appear
  p_legal_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode <= 3'd5);

  // R2: OFF holds without a synchronized power-on request
  p_off_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_OFF && !pwr_s) |=> mode == MODE_OFF);

  // R3: watchdog wait holds while the synchronized watchdog input is low
  p_wd_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_WATCHDOG && !wd_s) |=> mode == MODE_WATCHDOG);

  // R4: standby is reachable only from ON or STANDBY
  p_sby_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_ON && mode != MODE_STANDBY) |=> mode != MODE_STANDBY);

  // R4: ON with an event and a live watchdog enters standby
  p_sby_enter_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_ON && wd_s && sby_evt) |=> mode == MODE_STANDBY);

  // R7: standby leaves once the event clears
  p_sby_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_STANDBY && wd_s && !sby_evt) |=> mode == MODE_ON);

  // R8: watchdog loss picks the configured destination
  p_wd_loss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_ON || mode == MODE_STANDBY) && !wd_s)
      |=> mode == ($past(wdog_cold) ? MODE_COLD : MODE_OFF));

  // R9: cold start lasts one cycle
  p_cold_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode == MODE_COLD |=> mode == MODE_STARTUP);

  // R10: the flag follows the mode output
  p_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    standby_active == (mode == MODE_STANDBY));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .standby_active(standby_active),
  .pwr_s(pwr_s), .wd_s(wd_s), .sby_evt(sby_evt), .wdog_cold(wdog_cold)
);

// File: tb/pwr_mode_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_on_req = 1'b0, sby_cpu_pin = 1'b0, sby_per_pin = 1'b0;
  logic       cpu_pol_high = 1'b1, per_pol_high = 1'b1;
  logic       wdog_ok = 1'b0, wdog_cold = 1'b0;
  logic [2:0] mode;
  logic       standby_active;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  localparam int OFF = 0, SU = 1, ON = 2, SBY = 3, WD = 4, COLD = 5;

  always #4 clk = ~clk;

  pwr_mode_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_on_req(pwr_on_req),
    .sby_cpu_pin(sby_cpu_pin), .sby_per_pin(sby_per_pin),
    .cpu_pol_high(cpu_pol_high), .per_pol_high(per_pol_high),
    .wdog_ok(wdog_ok), .wdog_cold(wdog_cold),
    .mode(mode), .standby_active(standby_active)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic t_reset;
    tick(3);
    chk("R1 mode", int'(mode), OFF);
    chk("R1 flag", int'(standby_active), 0);
    rst_n = 1'b1;
    tick(4);
    chk("R1 idle off", int'(mode), OFF);
  endtask

  task automatic t_startup;
    pwr_on_req = 1'b1;
    tick(2);
    chk("R2 not yet", int'(mode), OFF);
    tick(1);
    chk("R2 enter startup", int'(mode), SU);
    pwr_on_req = 1'b0;
    tick(7);
    chk("R2 still startup", int'(mode), SU);
    tick(1);
    chk("R2 to watchdog", int'(mode), WD);
  endtask

  task automatic t_wdog_gate;
    tick(6);
    chk("R3 wait low wd", int'(mode), WD);
    wdog_ok = 1'b1;
    tick(2);
    chk("R3 two edges", int'(mode), WD);
    tick(1);
    chk("R3 to on", int'(mode), ON);
  endtask

  task automatic t_one_pin;
    sby_cpu_pin = 1'b1;
    tick(10);
    chk("R4 one request", int'(mode), ON);
    chk("R10 flag low on", int'(standby_active), 0);
  endtask

  task automatic t_filter;
    sby_per_pin = 1'b1;
    tick(2);
    sby_per_pin = 1'b0;
    tick(8);
    chk("R6 glitch ignored", int'(mode), ON);
    sby_per_pin = 1'b1;
    tick(5);
    chk("R6 five edges", int'(mode), ON);
    tick(1);
    chk("R6/R4 standby", int'(mode), SBY);
    chk("R10 flag high", int'(standby_active), 1);
  endtask

  task automatic t_exit;
    sby_per_pin = 1'b0;
    tick(5);
    chk("R7 still standby", int'(mode), SBY);
    tick(1);
    chk("R7 back on", int'(mode), ON);
    chk("R10 flag cleared", int'(standby_active), 0);
  endtask

  task automatic t_polarity;
    per_pol_high = 1'b0;
    tick(1);
    chk("R5 active low per", int'(mode), SBY);
    cpu_pol_high = 1'b0;
    tick(1);
    chk("R5 cpu inverted", int'(mode), ON);
    cpu_pol_high = 1'b1;
    tick(1);
    chk("R5 cpu restored", int'(mode), SBY);
  endtask

  task automatic t_wdog_off;
    wdog_cold = 1'b0;
    wdog_ok = 1'b0;
    tick(2);
    chk("R8 two edges", int'(mode), SBY);
    tick(1);
    chk("R8 to off", int'(mode), OFF);
    chk("R10 flag off", int'(standby_active), 0);
    tick(5);
    chk("R8 stays off", int'(mode), OFF);
  endtask

  task automatic t_pins_ignored;
    pwr_on_req = 1'b1;
    tick(3);
    chk("R3 restart", int'(mode), SU);
    pwr_on_req = 1'b0;
    tick(8);
    chk("R3 pins and low wd ignored", int'(mode), WD);
    tick(6);
    chk("R3 wd phase holds", int'(mode), WD);
    wdog_ok = 1'b1;
    tick(3);
    chk("R3 on first", int'(mode), ON);
    tick(1);
    chk("R4 event honoured in on", int'(mode), SBY);
  endtask

  task automatic t_cold;
    wdog_cold = 1'b1;
    wdog_ok = 1'b0;
    tick(3);
    chk("R8 cold start", int'(mode), COLD);
    tick(1);
    chk("R9 startup next", int'(mode), SU);
  endtask

  initial begin
    t_reset();
    t_startup();
    t_wdog_gate();
    t_one_pin();
    t_filter();
    t_exit();
    t_polarity();
    t_wdog_off();
    t_pins_ignored();
    t_cold();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule